// File: doc/BRIEF.md
# Interrupt-Driven Transfer Activation Arbiter

This block sits between a set of peripheral interrupt lines and a descriptor-driven transfer engine. Every source line has one enable bit. A request pulse is remembered per source until that source is served. While no activation is in flight, the arbiter serves the pending, enabled source with the smallest number. It reads one byte from a vector table, addresses the chosen descriptor through that byte, and hands the descriptor address to the engine together with a one-hot grant.

The vector table and the descriptors share one programmable upper address byte. The vector entry of source `s` lies at `{base, s}`. The descriptor lies at `{base, vector_byte}`. When the engine reports that the activating descriptor has run out and asks for an interrupt, the arbiter clears that source's enable bit and pulses the matching CPU interrupt line. Software sets and clears the enable bits by writing whole bytes, eight sources per byte.

Top module: `xfer_act_arbiter`

## Requirements
- R1: After reset all enable bits are 0, the grant is all zero, and `eng_start`, `mem_rd_req` and `cpu_irq` are low.
- R2: Source 0 is reserved. Its enable bit always reads 0, a request on it never starts an activation, and no vector read uses low byte 00h.
- R3: Writing enable byte `r` sets the enable bit of source `8*r + 7 - b` from data bit `b`. Data bit 7 of byte 0 maps to the reserved source 0.
- R4: A request from a source whose enable bit is 0 starts nothing. The request stays pending and starts an activation once the bit is set.
- R5: When several pending sources are enabled, the one with the lowest number is served first.
- R6: Requests that arrive during an activation stay latched per source. A source's pending flag is cleared when that source is taken, so one request pulse yields exactly one activation.
- R7: Each activation performs exactly one vector read, at address `{base, source number}`, with the source number zero-extended to 8 bits.
- R8: `eng_start` pulses for one cycle with a one-hot `eng_grant` for the served source and `eng_desc_addr = {base, vector byte}`. Both stay stable until `eng_done`.
- R9: A done with `eng_terminal=1` and `eng_raise=1` clears the served source's enable bit and pulses that source's `cpu_irq` bit for one cycle. Later requests from the source then start nothing.
- R10: A done with `eng_terminal=1` and `eng_raise=0` (repeat mode, interrupt off) leaves the enable bit set and raises no interrupt.
- R11: A done with `eng_terminal=0` leaves the enable bit set and raises no interrupt.
- R12: No new `eng_start` is issued before the engine reports done for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NSRC | Peripheral request lines, bit = source number |
| en_wr | input | NREG | Write strobe, one per enable byte |
| en_wdata | input | 8 | Enable byte write data |
| base_byte | input | 8 | Upper address byte of the vector table and descriptors |
| mem_rd_req | output | 1 | One-cycle vector read request |
| mem_rd_addr | output | 16 | Vector entry address |
| mem_rd_valid | input | 1 | Vector read data valid |
| mem_rd_data | input | 8 | Vector byte |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_grant | output | NSRC | One-hot served source |
| eng_desc_addr | output | 16 | Descriptor start address |
| eng_done | input | 1 | Engine has finished the activation |
| eng_terminal | input | 1 | Activating descriptor count went 01h to 00h |
| eng_raise | input | 1 | Terminal count should interrupt and disable |
| cpu_irq | output | NSRC | One-cycle completion interrupt per source |
| en_state | output | NSRC | Current enable bits |

## Verification
Activations are started from a lone request, from three requests in the same cycle, and from requests that arrive while the engine is still busy. These show whether ordering follows source number or arrival, and whether latching loses or duplicates a request. Requests to disabled sources, to the reserved source 0, and to a source enabled only after its request test masking and retained pending state. The three engine completion kinds (non-terminal, terminal with interrupt, terminal without) are each followed by a fresh request, which separates a cleared enable bit from a kept one. A change of the base byte confirms that it reaches both the vector address and the descriptor address.

// File: rtl/xact_pkg.sv
// Shared constants and the activation sequencer state type.
// Assumes byte-wide vector entries and a 16-bit address space.
package xact_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_VREQ,
        S_VWAIT,
        S_ISSUE,
        S_BUSY
    } seq_state_e;
endpackage

// File: rtl/xact_enable_bank.sv
// Per-source enable bits, written a byte at a time.
// Byte r, data bit b controls source 8*r + 7 - b. Source 0 is hardwired off.
// A hardware clear from the sequencer wins over a software write in the same cycle.
module xact_enable_bank #(
    parameter int NSRC = 40,
    parameter int NREG = (NSRC + 7) / 8,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] en_wr,
    input  logic [7:0]      en_wdata,
    input  logic            clr_valid,
    input  logic [IDXW-1:0] clr_idx,
    output logic [NSRC-1:0] en_bits
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        for (genvar b = 0; b < 8; b++) begin : g_bit
            localparam int S = r * 8 + 7 - b;
            if (S == 0) begin : g_rsvd
                assign en_bits[0] = 1'b0;
            end else if (S < NSRC) begin : g_live
                logic en_q;
                // Hold one enable bit: clear on terminal, else load on write.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        en_q <= 1'b0;
                    else if (clr_valid && clr_idx == IDXW'(S))
                        en_q <= 1'b0;
                    else if (en_wr[r])
                        en_q <= en_wdata[b];
                end
                assign en_bits[S] = en_q;
            end
        end
    end

    assert_clear_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |=> !en_bits[$past(clr_idx)]);

    assert_rsvd_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_bits[0]);
endmodule

// File: rtl/xact_pend_pick.sv
// Latches request pulses per source and picks the lowest-numbered
// pending source whose enable bit is set. Source 0 never latches.
// A taken source's flag clears unless a new request arrives in that cycle.
module xact_pend_pick #(
    parameter int NSRC = 40,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] en,
    input  logic            take,
    input  logic [IDXW-1:0] take_idx,
    output logic            pick_valid,
    output logic [IDXW-1:0] pick_idx
);
    localparam logic [NSRC-1:0] RSVD_MASK = NSRC'(1);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] cand;

    // Build the clear mask for the source being taken.
    always_comb begin
        clr_mask = '0;
        if (take)
            clr_mask = NSRC'(1) << take_idx;
    end

    // Keep pending flags; new requests override a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= ((pend_q & ~clr_mask) | req) & ~RSVD_MASK;
    end

    assign cand       = pend_q & en & ~RSVD_MASK;
    assign pick_valid = |cand;

    // Fixed priority: scan downwards so the lowest set index remains.
    always_comb begin
        pick_idx = '0;
        for (int i = NSRC - 1; i >= 1; i--) begin
            if (cand[i])
                pick_idx = IDXW'(i);
        end
    end

    assert_take_is_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (pend_q[take_idx] && en[take_idx]));

    assert_pend_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req[take_idx]) |=> !pend_q[$past(take_idx)]);
endmodule

// File: rtl/xact_seq.sv
// Activation sequencer: takes the picked source, reads its vector byte,
// issues the grant and descriptor address, waits for the engine, and
// handles the terminal-count outcome. Assumes the memory answers each
// read with exactly one valid pulse and the engine gives one done per start.
module xact_seq #(
    parameter int NSRC = 40,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pick_valid,
    input  logic [IDXW-1:0]           pick_idx,
    input  logic [7:0]                base_byte,
    output logic                      mem_rd_req,
    output logic [xact_pkg::ADDR_W-1:0] mem_rd_addr,
    input  logic                      mem_rd_valid,
    input  logic [7:0]                mem_rd_data,
    output logic                      eng_start,
    output logic [NSRC-1:0]           eng_grant,
    output logic [xact_pkg::ADDR_W-1:0] eng_desc_addr,
    input  logic                      eng_done,
    input  logic                      eng_terminal,
    input  logic                      eng_raise,
    output logic                      take,
    output logic [IDXW-1:0]           take_idx,
    output logic                      clr_valid,
    output logic [IDXW-1:0]           clr_idx,
    output logic [NSRC-1:0]           cpu_irq
);
    import xact_pkg::*;

    seq_state_e          state_q;
    logic [IDXW-1:0]     cur_q;
    logic [ADDR_W-1:0]   desc_q;
    logic [NSRC-1:0]     grant_q;
    logic [NSRC-1:0]     irq_q;
    logic                finish_int;

    assign take       = (state_q == S_IDLE) && pick_valid;
    assign take_idx   = pick_idx;
    assign finish_int = (state_q == S_BUSY) && eng_done && eng_terminal && eng_raise;
    assign clr_valid  = finish_int;
    assign clr_idx    = cur_q;

    assign mem_rd_req    = (state_q == S_VREQ);
    assign mem_rd_addr   = {base_byte, BYTE_W'(cur_q)};
    assign eng_start     = (state_q == S_ISSUE);
    assign eng_grant     = grant_q;
    assign eng_desc_addr = desc_q;
    assign cpu_irq       = irq_q;

    // Step through read, issue and wait phases of one activation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            desc_q  <= '0;
            grant_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (take) begin
                        cur_q   <= pick_idx;
                        state_q <= S_VREQ;
                    end
                end
                S_VREQ:  state_q <= S_VWAIT;
                S_VWAIT: begin
                    if (mem_rd_valid) begin
                        desc_q  <= {base_byte, mem_rd_data};
                        grant_q <= NSRC'(1) << cur_q;
                        state_q <= S_ISSUE;
                    end
                end
                S_ISSUE: state_q <= S_BUSY;
                S_BUSY: begin
                    if (eng_done) begin
                        grant_q <= '0;
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Pulse the completion interrupt for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= '0;
        else if (finish_int)
            irq_q <= NSRC'(1) << cur_q;
        else
            irq_q <= '0;
    end

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_grant));

    assert_start_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> ($countones(eng_grant) == 1));

    assert_grant_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_grant != '0) && $past(eng_grant != '0)) |-> $stable(eng_grant));

    assert_irq_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |-> $past(eng_done && eng_terminal && eng_raise));

    assert_no_rsvd_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[BYTE_W-1:0] != '0));
endmodule

// File: rtl/xfer_act_arbiter.sv
// Top of the transfer activation arbiter. Ties the enable bank, the
// pending/priority picker and the activation sequencer together.
// Assumes NSRC <= 256 so a source number fits the low address byte,
// and that base_byte is stable during an activation.
module xfer_act_arbiter #(
    parameter int NSRC = 40,
    parameter int NREG = (NSRC + 7) / 8,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NREG-1:0] en_wr,
    input  logic [7:0]      en_wdata,
    input  logic [7:0]      base_byte,
    output logic            mem_rd_req,
    output logic [15:0]     mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [7:0]      mem_rd_data,
    output logic            eng_start,
    output logic [NSRC-1:0] eng_grant,
    output logic [15:0]     eng_desc_addr,
    input  logic            eng_done,
    input  logic            eng_terminal,
    input  logic            eng_raise,
    output logic [NSRC-1:0] cpu_irq,
    output logic [NSRC-1:0] en_state
);
    logic            pick_valid;
    logic [IDXW-1:0] pick_idx;
    logic            take;
    logic [IDXW-1:0] take_idx;
    logic            clr_valid;
    logic [IDXW-1:0] clr_idx;

    xact_enable_bank #(.NSRC(NSRC), .NREG(NREG), .IDXW(IDXW)) u_enables (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .clr_valid (clr_valid),
        .clr_idx   (clr_idx),
        .en_bits   (en_state)
    );

    xact_pend_pick #(.NSRC(NSRC), .IDXW(IDXW)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (irq_req),
        .en         (en_state),
        .take       (take),
        .take_idx   (take_idx),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    xact_seq #(.NSRC(NSRC), .IDXW(IDXW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .pick_valid    (pick_valid),
        .pick_idx      (pick_idx),
        .base_byte     (base_byte),
        .mem_rd_req    (mem_rd_req),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_data   (mem_rd_data),
        .eng_start     (eng_start),
        .eng_grant     (eng_grant),
        .eng_desc_addr (eng_desc_addr),
        .eng_done      (eng_done),
        .eng_terminal  (eng_terminal),
        .eng_raise     (eng_raise),
        .take          (take),
        .take_idx      (take_idx),
        .clr_valid     (clr_valid),
        .clr_idx       (clr_idx),
        .cpu_irq       (cpu_irq)
    );

    assert_irq_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |-> ((cpu_irq & en_state) == '0));
endmodule

// File: tb/xfer_act_arbiter_tb.sv
// Scoreboard bench: tasks queue expected activations, monitors compare
// vector reads and engine starts. Memory and engine are behavioural.
module xfer_act_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 40;
    localparam int NREG = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic [NREG-1:0] en_wr = '0;
    logic [7:0]      en_wdata = '0;
    logic [7:0]      base_byte = 8'hFD;
    logic            mem_rd_req;
    logic [15:0]     mem_rd_addr;
    logic            mem_rd_valid = 1'b0;
    logic [7:0]      mem_rd_data = '0;
    logic            eng_start;
    logic [NSRC-1:0] eng_grant;
    logic [15:0]     eng_desc_addr;
    logic            eng_done = 1'b0;
    logic            eng_terminal = 1'b0;
    logic            eng_raise = 1'b0;
    logic [NSRC-1:0] cpu_irq;
    logic [NSRC-1:0] en_state;

    xfer_act_arbiter #(.NSRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .en_wr(en_wr),
        .en_wdata(en_wdata), .base_byte(base_byte), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .eng_start(eng_start), .eng_grant(eng_grant),
        .eng_desc_addr(eng_desc_addr), .eng_done(eng_done),
        .eng_terminal(eng_terminal), .eng_raise(eng_raise),
        .cpu_irq(cpu_irq), .en_state(en_state)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int starts = 0;
    int irq_cnt [NSRC];
    bit busy = 1'b0;
    bit cfg_term = 1'b0;
    bit cfg_raise = 1'b0;
    int cfg_lat = 2;
    logic [7:0] shadow [NREG];
    int exp_src [$];
    logic [15:0] exp_desc [$];

    function automatic logic [7:0] vec_of(input int s);
        return 8'h40 + 8'((s % 24) * 8);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_act(input int s);
        exp_src.push_back(s);
        exp_desc.push_back({base_byte, vec_of(s)});
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        @(negedge clk) irq_req = m;
        @(negedge clk) irq_req = '0;
    endtask

    task automatic write_reg(input int r);
        @(negedge clk);
        en_wr = '0;
        en_wr[r] = 1'b1;
        en_wdata = shadow[r];
        @(negedge clk) en_wr = '0;
    endtask

    task automatic set_en(input int s, input bit v);
        shadow[s / 8][7 - (s % 8)] = v;
        write_reg(s / 8);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Memory model: answer a vector read two negedges after the request.
    initial begin
        bit due = 1'b0;
        logic [7:0] rsp = '0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (due) begin
                mem_rd_valid = 1'b1;
                mem_rd_data = rsp;
                due = 1'b0;
            end
            if (mem_rd_req) begin
                due = 1'b1;
                rsp = (mem_rd_addr[15:8] == base_byte) ? vec_of(int'(mem_rd_addr[7:0])) : 8'hEE;
            end
        end
    end

    // Engine model: report done cfg_lat negedges after a start.
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (eng_start) begin
                repeat (cfg_lat) @(negedge clk);
                eng_done = 1'b1;
                eng_terminal = cfg_term;
                eng_raise = cfg_raise;
                busy = 1'b0;
            end
        end
    end

    // Monitor: compare vector reads and starts with the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int i = 0; i < NSRC; i++) irq_cnt[i] += int'(cpu_irq[i]);
                if (mem_rd_req) begin
                    if (exp_src.size() == 0)
                        chk(1'b0, "R7 unexpected vector read", mem_rd_addr, 0);
                    else
                        chk(mem_rd_addr == {base_byte, 8'(exp_src[0])}, "R7 vector address",
                            mem_rd_addr, {base_byte, 8'(exp_src[0])});
                end
                if (eng_start) begin
                    starts++;
                    chk(!busy, "R12 start while busy", 1, 0);
                    busy = 1'b1;
                    if (exp_src.size() == 0) begin
                        chk(1'b0, "R5 unexpected start", eng_grant, 0);
                    end else begin
                        int s;
                        logic [15:0] d;
                        s = exp_src.pop_front();
                        d = exp_desc.pop_front();
                        chk(eng_grant == (NSRC'(1) << s), "R5 R8 grant", eng_grant, NSRC'(1) << s);
                        chk(eng_desc_addr == d, "R8 descriptor address", eng_desc_addr, d);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int s0;
        for (int i = 0; i < NSRC; i++) irq_cnt[i] = 0;
        for (int r = 0; r < NREG; r++) shadow[r] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(en_state == '0, "R1 enables", en_state, 0);
        chk(eng_grant == '0 && !eng_start, "R1 grant", eng_grant, 0);
        chk(!mem_rd_req && cpu_irq == '0, "R1 read/irq", cpu_irq, 0);

        // R3: byte 2 data bit 5 -> source 18
        shadow[2] = 8'b0010_0000;
        write_reg(2);
        chk(en_state == (NSRC'(1) << 18), "R3 bit mapping", en_state, NSRC'(1) << 18);
        shadow[2] = 8'h00;
        write_reg(2);

        // R2: reserved source 0
        shadow[0] = 8'h80;
        write_reg(0);
        chk(en_state[0] == 1'b0, "R2 reserved enable", en_state[0], 0);
        s0 = starts;
        pulse(NSRC'(1));
        settle(30);
        chk(starts == s0, "R2 reserved start", starts, s0);
        shadow[0] = 8'h00;
        write_reg(0);

        // R7 R8 R11: single non-terminal activation
        cfg_term = 1'b0; cfg_raise = 1'b1; cfg_lat = 2;
        set_en(5, 1'b1);
        s0 = starts;
        expect_act(5);
        pulse(NSRC'(1) << 5);
        settle(30);
        chk(starts == s0 + 1, "R7 one activation", starts, s0 + 1);
        chk(en_state[5] == 1'b1, "R11 enable kept", en_state[5], 1);
        chk(irq_cnt[5] == 0, "R11 no interrupt", irq_cnt[5], 0);

        // R5: simultaneous requests 39, 12, 3
        set_en(3, 1'b1); set_en(12, 1'b1); set_en(39, 1'b1);
        expect_act(3); expect_act(12); expect_act(39);
        pulse((NSRC'(1) << 3) | (NSRC'(1) << 12) | (NSRC'(1) << 39));
        settle(60);
        chk(exp_src.size() == 0, "R5 all served", exp_src.size(), 0);

        // R6 R12: requests latched while busy, then ordered by number
        cfg_lat = 15;
        set_en(20, 1'b1); set_en(10, 1'b1); set_en(30, 1'b1);
        s0 = starts;
        expect_act(20); expect_act(10); expect_act(30);
        pulse(NSRC'(1) << 20);
        settle(6);
        pulse(NSRC'(1) << 30);
        pulse(NSRC'(1) << 10);
        settle(100);
        chk(starts == s0 + 3, "R6 latched count", starts, s0 + 3);
        cfg_lat = 2;

        // R4: disabled source stays pending
        s0 = starts;
        pulse(NSRC'(1) << 7);
        settle(30);
        chk(starts == s0, "R4 disabled no start", starts, s0);
        expect_act(7);
        set_en(7, 1'b1);
        settle(30);
        chk(starts == s0 + 1, "R4 start after enable", starts, s0 + 1);

        // R9: terminal with interrupt
        cfg_term = 1'b1; cfg_raise = 1'b1;
        set_en(9, 1'b1);
        expect_act(9);
        pulse(NSRC'(1) << 9);
        settle(30);
        chk(en_state[9] == 1'b0, "R9 enable cleared", en_state[9], 0);
        chk(irq_cnt[9] == 1, "R9 interrupt pulse", irq_cnt[9], 1);
        shadow[1][6] = 1'b0;
        s0 = starts;
        pulse(NSRC'(1) << 9);
        settle(30);
        chk(starts == s0, "R9 no restart", starts, s0);

        // R10: terminal without interrupt
        cfg_raise = 1'b0;
        set_en(11, 1'b1);
        s0 = starts;
        expect_act(11);
        pulse(NSRC'(1) << 11);
        settle(30);
        chk(en_state[11] == 1'b1, "R10 enable kept", en_state[11], 1);
        chk(irq_cnt[11] == 0, "R10 no interrupt", irq_cnt[11], 0);
        expect_act(11);
        pulse(NSRC'(1) << 11);
        settle(30);
        chk(starts == s0 + 2, "R10 restarts", starts, s0 + 2);

        // R7 R8: new base byte
        cfg_term = 1'b0;
        base_byte = 8'h3A;
        expect_act(5);
        pulse(NSRC'(1) << 5);
        settle(30);

        chk(exp_src.size() == 0, "R6 scoreboard empty", exp_src.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule